// File: doc/BRIEF.md
# Exception Entry and Return Controller

This block decides which pending exception a processor takes next and produces the register-file strobes that carry out the switch. Seven sources feed it: a reset request, an undefined-instruction flag, a software-interrupt flag, a prefetch-abort flag, a data-abort flag, a normal interrupt line and a fast interrupt line. The pipeline raises the prefetch-abort flag only when the aborted instruction reaches the execute stage, not at fetch time. Interrupts are gated by two mask bits of the current status word. The controller picks the highest-priority eligible source. It then issues one cycle of strobes that write the link register with the next instruction address and copy the current status into the saved status of the target mode. The same strobes write a new current status, with the mode field forced and the mask bits set, and load the program counter with the vector.

A return request works the other way. The saved status is written back into the current status, and the program counter is loaded with the link value minus an offset that depends on the kind of exception being left. The register storage and the pipeline are outside the block. The block only computes the data and the write enables, one clock after it samples its inputs.

Top module: `trap_sequencer`

## Requirements
- R1: After reset, and in any cycle that follows a cycle with no eligible request and no valid return request, every write strobe (`lr_we`, `spsr_we`, `cpsr_we`, `pc_we`) and both `entry_o` and `return_o` are 0.
- R2: When several sources are eligible, exactly one is taken, chosen by fixed priority: reset, data abort, fast interrupt, interrupt, prefetch abort, undefined instruction, software interrupt (highest first).
- R3: The interrupt line is eligible only while bit 7 (I) of `cur_status` is 0, and the fast interrupt line only while bit 6 (F) is 0. The other five sources ignore both bits.
- R4: On entry, `pc_data` equals the vector `code*4`, and `code_o` gives the exception code: reset 0, undefined 1, software interrupt 2, prefetch abort 3, data abort 4, interrupt 6, fast interrupt 7 (code 5 is unused).
- R5: On entry for any source except reset, `lr_we` is 1 and `lr_data` equals the `next_addr` sampled one cycle earlier. On reset entry `lr_we` is 0.
- R6: On entry for any source except reset, `spsr_we` is 1 and `spsr_data` equals the sampled `cur_status`. On reset entry `spsr_we` is 0.
- R7: On entry, `cpsr_data` equals the sampled `cur_status` with bits [4:0] replaced by the target mode (0x13 for reset and software interrupt, 0x1B for undefined, 0x17 for both aborts, 0x12 for interrupt, 0x11 for fast interrupt), with bit 7 set, and with bit 6 also set for reset and fast interrupt. All other bits are unchanged.
- R8: On a return request with `ret_kind` in {1,2,3,4,6,7}, the next cycle has `cpsr_we`=1 with `cpsr_data`=`saved_status`, and `pc_we`=1 with `pc_data`=`link_in` minus 4 for kinds 3, 6 and 7, minus 8 for kind 4, and minus 0 for kinds 1 and 2.
- R9: A return request with `ret_kind` 0 or 5 has no effect. A return request in the same cycle as an eligible exception is dropped and the entry is performed.
- R10: Every strobe is registered: it appears in the cycle after the inputs are sampled and lasts one cycle per sampled request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset of the controller |
| rst_req | input | 1 | Reset exception request |
| undef_req | input | 1 | Undefined-instruction flag |
| swi_req | input | 1 | Software-interrupt flag |
| pabort_req | input | 1 | Prefetch abort, raised at execute |
| dabort_req | input | 1 | Data abort |
| irq_req | input | 1 | Interrupt line |
| fiq_req | input | 1 | Fast interrupt line |
| cur_status | input | STAT_W | Current status word |
| next_addr | input | ADDR_W | Address of the next instruction |
| ret_req | input | 1 | Return-from-exception request |
| ret_kind | input | 3 | Exception code being returned from |
| saved_status | input | STAT_W | Saved status of the current mode |
| link_in | input | ADDR_W | Link register of the current mode |
| lr_we | output | 1 | Link register write enable |
| lr_data | output | ADDR_W | Link register write data |
| spsr_we | output | 1 | Saved status write enable |
| spsr_data | output | STAT_W | Saved status write data |
| cpsr_we | output | 1 | Current status write enable |
| cpsr_data | output | STAT_W | Current status write data |
| pc_we | output | 1 | Program counter load enable |
| pc_data | output | ADDR_W | Program counter load value |
| entry_o | output | 1 | Entry sequence this cycle |
| return_o | output | 1 | Return sequence this cycle |
| code_o | output | 3 | Exception code of the entry or return |

## Verification
A wrong arbitration or mask decision shows one cycle after the request pattern is applied: `code_o` and `pc_data` name the wrong source, or no strobe appears at all. The bench sweeps every combination of the seven sources against all four mask settings. A corrupted status transform shows in the same cycle as a wrong mode field or mask bit in `cpsr_data`, or as a saved-status copy that does not match the input. Return-offset faults show in `pc_data` on the single return cycle for each kind.

// File: rtl/trap_pkg.sv
package trap_pkg;

   typedef enum logic [2:0] {
      EX_RESET = 3'd0,
      EX_UNDEF = 3'd1,
      EX_SWI   = 3'd2,
      EX_PABT  = 3'd3,
      EX_DABT  = 3'd4,
      EX_RSVD  = 3'd5,
      EX_IRQ   = 3'd6,
      EX_FIQ   = 3'd7
   } exc_code_e;

   localparam int NUM_SRC = 7;
   localparam int MODE_W  = 5;

   // Source index in priority order (0 = highest) to exception code.
   function automatic exc_code_e prio_code(input int idx);
      case (idx)
         0:       return EX_RESET;
         1:       return EX_DABT;
         2:       return EX_FIQ;
         3:       return EX_IRQ;
         4:       return EX_PABT;
         5:       return EX_UNDEF;
         default: return EX_SWI;
      endcase
   endfunction

   function automatic logic [MODE_W-1:0] mode_of(input exc_code_e c);
      case (c)
         EX_RESET, EX_SWI: return 5'h13;
         EX_UNDEF:         return 5'h1B;
         EX_PABT, EX_DABT: return 5'h17;
         EX_IRQ:           return 5'h12;
         EX_FIQ:           return 5'h11;
         default:          return 5'h13;
      endcase
   endfunction

   function automatic logic sets_fmask(input exc_code_e c);
      return (c == EX_RESET) || (c == EX_FIQ);
   endfunction

endpackage

// File: rtl/trap_arbiter.sv
module trap_arbiter
   import trap_pkg::*;
#(
   parameter int STAT_W = 32,
   parameter int I_BIT  = 7,
   parameter int F_BIT  = 6
) (
   input  logic [NUM_SRC-1:0] src_req,
   input  logic [STAT_W-1:0]  cur_status,
   output logic [NUM_SRC-1:0] grant_oh,
   output logic               grant_vld,
   output exc_code_e          grant_code
);

   logic [NUM_SRC-1:0] eligible;
   logic [NUM_SRC:0]   higher_seen;

   assign higher_seen[0] = 1'b0;

   for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
      if (prio_code(g) == EX_IRQ) begin : g_imask
         assign eligible[g] = src_req[g] & ~cur_status[I_BIT];
      end else if (prio_code(g) == EX_FIQ) begin : g_fmask
         assign eligible[g] = src_req[g] & ~cur_status[F_BIT];
      end else begin : g_plain
         assign eligible[g] = src_req[g];
      end
      assign grant_oh[g]      = eligible[g] & ~higher_seen[g];
      assign higher_seen[g+1] = higher_seen[g] | eligible[g];
   end

   assign grant_vld = higher_seen[NUM_SRC];

   always_comb begin
      grant_code = EX_RESET;
      for (int k = NUM_SRC - 1; k >= 0; k--) begin
         if (grant_oh[k]) grant_code = prio_code(k);
      end
   end

endmodule

// File: rtl/trap_entry_calc.sv
module trap_entry_calc
   import trap_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int STAT_W   = 32,
   parameter int I_BIT    = 7,
   parameter int F_BIT    = 6,
   parameter bit HIGH_VEC = 1'b0
) (
   input  exc_code_e          code,
   input  logic [STAT_W-1:0]  cur_status,
   output logic [ADDR_W-1:0]  vector,
   output logic [STAT_W-1:0]  new_status
);

   localparam int LOW_W = 16;
   logic [ADDR_W-1:0] base;

   if (HIGH_VEC) begin : g_high
      assign base = {{(ADDR_W-LOW_W){1'b1}}, {LOW_W{1'b0}}};
   end else begin : g_low
      assign base = '0;
   end

   assign vector = base | {{(ADDR_W-5){1'b0}}, code, 2'b00};

   always_comb begin
      new_status               = cur_status;
      new_status[MODE_W-1:0]   = mode_of(code);
      new_status[I_BIT]        = 1'b1;
      if (sets_fmask(code)) new_status[F_BIT] = 1'b1;
   end

endmodule

// File: rtl/trap_return_calc.sv
module trap_return_calc
   import trap_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic [2:0]        ret_kind,
   input  logic [ADDR_W-1:0] link_in,
   output logic              ret_ok,
   output logic [ADDR_W-1:0] ret_pc
);

   logic [3:0] offset;

   always_comb begin
      ret_ok = 1'b1;
      offset = 4'd0;
      case (exc_code_e'(ret_kind))
         EX_IRQ, EX_FIQ, EX_PABT: offset = 4'd4;
         EX_DABT:                 offset = 4'd8;
         EX_UNDEF, EX_SWI:        offset = 4'd0;
         default:                 ret_ok = 1'b0;
      endcase
   end

   assign ret_pc = link_in - {{(ADDR_W-4){1'b0}}, offset};

endmodule

// File: rtl/trap_sequencer.sv
module trap_sequencer
   import trap_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int STAT_W   = 32,
   parameter int I_BIT    = 7,
   parameter int F_BIT    = 6,
   parameter bit HIGH_VEC = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rst_req,
   input  logic              undef_req,
   input  logic              swi_req,
   input  logic              pabort_req,
   input  logic              dabort_req,
   input  logic              irq_req,
   input  logic              fiq_req,
   input  logic [STAT_W-1:0] cur_status,
   input  logic [ADDR_W-1:0] next_addr,
   input  logic              ret_req,
   input  logic [2:0]        ret_kind,
   input  logic [STAT_W-1:0] saved_status,
   input  logic [ADDR_W-1:0] link_in,
   output logic              lr_we,
   output logic [ADDR_W-1:0] lr_data,
   output logic              spsr_we,
   output logic [STAT_W-1:0] spsr_data,
   output logic              cpsr_we,
   output logic [STAT_W-1:0] cpsr_data,
   output logic              pc_we,
   output logic [ADDR_W-1:0] pc_data,
   output logic              entry_o,
   output logic              return_o,
   output logic [2:0]        code_o
);

   if (ADDR_W < 17 || ADDR_W > 64) begin : g_bad_addr
      $error("trap_sequencer: ADDR_W out of range");
   end
   if (STAT_W < 8 || I_BIT >= STAT_W || F_BIT >= STAT_W) begin : g_bad_stat
      $error("trap_sequencer: status layout out of range");
   end
   if (I_BIT == F_BIT || I_BIT < MODE_W || F_BIT < MODE_W) begin : g_bad_bits
      $error("trap_sequencer: mask bits overlap mode field or each other");
   end

   logic [NUM_SRC-1:0] src_req;
   logic [NUM_SRC-1:0] grant_oh;
   logic               grant_vld;
   exc_code_e          grant_code;
   logic [ADDR_W-1:0]  vector;
   logic [STAT_W-1:0]  new_status;
   logic               ret_ok;
   logic [ADDR_W-1:0]  ret_pc;

   // priority order: reset, dabort, fiq, irq, pabort, undef, swi
   assign src_req = {swi_req, undef_req, pabort_req, irq_req,
                     fiq_req, dabort_req, rst_req};

   trap_arbiter #(.STAT_W(STAT_W), .I_BIT(I_BIT), .F_BIT(F_BIT)) u_arb (
      .src_req    (src_req),
      .cur_status (cur_status),
      .grant_oh   (grant_oh),
      .grant_vld  (grant_vld),
      .grant_code (grant_code)
   );

   trap_entry_calc #(
      .ADDR_W(ADDR_W), .STAT_W(STAT_W), .I_BIT(I_BIT), .F_BIT(F_BIT),
      .HIGH_VEC(HIGH_VEC)
   ) u_entry (
      .code       (grant_code),
      .cur_status (cur_status),
      .vector     (vector),
      .new_status (new_status)
   );

   trap_return_calc #(.ADDR_W(ADDR_W)) u_ret (
      .ret_kind (ret_kind),
      .link_in  (link_in),
      .ret_ok   (ret_ok),
      .ret_pc   (ret_pc)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lr_we     <= 1'b0;
         lr_data   <= '0;
         spsr_we   <= 1'b0;
         spsr_data <= '0;
         cpsr_we   <= 1'b0;
         cpsr_data <= '0;
         pc_we     <= 1'b0;
         pc_data   <= '0;
         entry_o   <= 1'b0;
         return_o  <= 1'b0;
         code_o    <= '0;
      end else begin
         lr_we    <= 1'b0;
         spsr_we  <= 1'b0;
         cpsr_we  <= 1'b0;
         pc_we    <= 1'b0;
         entry_o  <= 1'b0;
         return_o <= 1'b0;
         if (grant_vld) begin
            entry_o   <= 1'b1;
            code_o    <= grant_code;
            pc_we     <= 1'b1;
            pc_data   <= vector;
            cpsr_we   <= 1'b1;
            cpsr_data <= new_status;
            lr_we     <= (grant_code != EX_RESET);
            lr_data   <= next_addr;
            spsr_we   <= (grant_code != EX_RESET);
            spsr_data <= cur_status;
         end else if (ret_req && ret_ok) begin
            return_o  <= 1'b1;
            code_o    <= ret_kind;
            cpsr_we   <= 1'b1;
            cpsr_data <= saved_status;
            pc_we     <= 1'b1;
            pc_data   <= ret_pc;
         end
      end
   end

   // R2: the arbiter never grants two sources at once
   p_single_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant_oh));

   // R3: an interrupt entry only follows a cycle with I clear
   p_irq_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (entry_o && code_o == EX_IRQ) |-> !$past(cur_status[I_BIT]));

   // R3: a fast interrupt entry only follows a cycle with F clear
   p_fiq_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (entry_o && code_o == EX_FIQ) |-> !$past(cur_status[F_BIT]));

   // R5, R6: reset entry writes neither link nor saved status
   p_reset_nolink_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (entry_o && code_o == EX_RESET) |-> (!lr_we && !spsr_we));

   // R7: every entry masks the interrupt line
   p_entry_imask_r7: assert property (@(posedge clk) disable iff (!rst_n)
      entry_o |-> (cpsr_we && cpsr_data[I_BIT]));

   // R9: entry and return never share a cycle
   p_excl_seq_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(entry_o && return_o));

   // R8: a return always loads both status and program counter
   p_ret_pair_r8: assert property (@(posedge clk) disable iff (!rst_n)
      return_o |-> (cpsr_we && pc_we && !lr_we && !spsr_we));

endmodule

// File: tb/trap_sequencer_bench.sv
module trap_sequencer_bench;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rst_req = 0, undef_req = 0, swi_req = 0, pabort_req = 0;
   logic        dabort_req = 0, irq_req = 0, fiq_req = 0;
   logic [31:0] cur_status = 32'h6000_0010;
   logic [31:0] next_addr = '0;
   logic        ret_req = 0;
   logic [2:0]  ret_kind = '0;
   logic [31:0] saved_status = '0;
   logic [31:0] link_in = '0;
   logic        lr_we, spsr_we, cpsr_we, pc_we, entry_o, return_o;
   logic [31:0] lr_data, spsr_data, cpsr_data, pc_data;
   logic [2:0]  code_o;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   trap_sequencer u_trap_sequencer (
      .clk(clk), .rst_n(rst_n),
      .rst_req(rst_req), .undef_req(undef_req), .swi_req(swi_req),
      .pabort_req(pabort_req), .dabort_req(dabort_req),
      .irq_req(irq_req), .fiq_req(fiq_req),
      .cur_status(cur_status), .next_addr(next_addr),
      .ret_req(ret_req), .ret_kind(ret_kind),
      .saved_status(saved_status), .link_in(link_in),
      .lr_we(lr_we), .lr_data(lr_data), .spsr_we(spsr_we), .spsr_data(spsr_data),
      .cpsr_we(cpsr_we), .cpsr_data(cpsr_data), .pc_we(pc_we), .pc_data(pc_data),
      .entry_o(entry_o), .return_o(return_o), .code_o(code_o)
   );

   task automatic check(input bit ok, input string req, input logic [63:0] act,
                        input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // req bit order: 0 rst,1 undef,2 swi,3 pabt,4 dabt,5 irq,6 fiq
   function automatic int pick(input logic [6:0] r, input bit im, input bit fm);
      if (r[0]) return 0;
      if (r[4]) return 4;
      if (r[6] && !fm) return 7;
      if (r[5] && !im) return 6;
      if (r[3]) return 3;
      if (r[1]) return 1;
      if (r[2]) return 2;
      return -1;
   endfunction

   function automatic logic [4:0] mode_exp(input int c);
      case (c)
         0, 2: return 5'h13;
         1:    return 5'h1B;
         3, 4: return 5'h17;
         6:    return 5'h12;
         default: return 5'h11;
      endcase
   endfunction

   task automatic idle_check();
      @(negedge clk);
      check(!(lr_we | spsr_we | cpsr_we | pc_we | entry_o | return_o), "R1 idle",
            {lr_we, spsr_we, cpsr_we, pc_we, entry_o, return_o}, 0);
   endtask

   initial begin : watchdog
      #(CLK_PERIOD * 100000);
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin : stim
      #(CLK_PERIOD * 3);
      @(negedge clk);
      check(!(lr_we | spsr_we | cpsr_we | pc_we | entry_o | return_o), "R1 reset",
            {lr_we, spsr_we, cpsr_we, pc_we, entry_o, return_o}, 0);
      rst_n = 1'b1;
      idle_check();

      // Entry sweep: all request patterns against all mask settings (R2..R7, R10)
      for (int m = 0; m < 4; m++) begin
         for (int r = 0; r < 128; r++) begin
            automatic bit im = m[0];
            automatic bit fm = m[1];
            automatic logic [31:0] st = 32'h6A00_0C10 | (32'(im) << 7) | (32'(fm) << 6)
                                        | 32'(r << 8);
            automatic logic [31:0] na = 32'h0001_0000 + 32'(r * 4 + m * 1024);
            automatic int w = pick(7'(r), im, fm);
            automatic logic [31:0] exp_st;
            @(negedge clk);
            {fiq_req, irq_req, dabort_req, pabort_req, swi_req, undef_req, rst_req} = 7'(r);
            cur_status = st;
            next_addr  = na;
            @(negedge clk);
            {fiq_req, irq_req, dabort_req, pabort_req, swi_req, undef_req, rst_req} = '0;
            if (w < 0) begin
               check(!entry_o && !pc_we, "R3 no eligible source", {entry_o, pc_we}, 0);
            end else begin
               exp_st = (st & ~32'h1F) | 32'(mode_exp(w)) | 32'h80
                        | ((w == 0 || w == 7) ? 32'h40 : 32'h0);
               check(entry_o && code_o == 3'(w), "R2 priority winner", code_o, w);
               check(pc_we && pc_data == 32'(w * 4), "R4 vector", pc_data, w * 4);
               check(cpsr_we && cpsr_data == exp_st, "R7 new status", cpsr_data, exp_st);
               if (w == 0) begin
                  check(!lr_we && !spsr_we, "R5 R6 reset writes no link", {lr_we, spsr_we}, 0);
               end else begin
                  check(lr_we && lr_data == na, "R5 link address", lr_data, na);
                  check(spsr_we && spsr_data == st, "R6 saved status", spsr_data, st);
               end
            end
            @(negedge clk);
            check(!entry_o && !pc_we, "R10 single-cycle strobe", {entry_o, pc_we}, 0);
         end
      end

      // Return sweep over all kinds (R8, R9)
      for (int k = 0; k < 8; k++) begin
         automatic logic [31:0] lk = 32'h0000_4000 + 32'(k * 256);
         automatic logic [31:0] ss = 32'h1234_5600 + 32'(k);
         automatic int off = (k == 3 || k == 6 || k == 7) ? 4 : (k == 4 ? 8 : 0);
         @(negedge clk);
         ret_req = 1'b1; ret_kind = 3'(k); link_in = lk; saved_status = ss;
         @(negedge clk);
         ret_req = 1'b0;
         if (k == 0 || k == 5) begin
            check(!return_o && !cpsr_we && !pc_we, "R9 ignored return kind",
                  {return_o, cpsr_we, pc_we}, 0);
         end else begin
            check(return_o && cpsr_we && cpsr_data == ss, "R8 status restore", cpsr_data, ss);
            check(pc_we && pc_data == lk - 32'(off), "R8 return pc", pc_data, lk - 32'(off));
            check(!lr_we && !spsr_we, "R8 no link write", {lr_we, spsr_we}, 0);
         end
         idle_check();
      end

      // Return and exception in the same cycle: entry wins (R9)
      @(negedge clk);
      cur_status = 32'h0000_0010;
      ret_req = 1'b1; ret_kind = 3'd6; link_in = 32'h8000; saved_status = 32'h55;
      irq_req = 1'b1; next_addr = 32'h2220;
      @(negedge clk);
      ret_req = 1'b0; irq_req = 1'b0;
      check(entry_o && !return_o && code_o == 3'd6, "R9 entry beats return",
            {entry_o, return_o, code_o}, {1'b1, 1'b0, 3'd6});
      check(pc_data == 32'h18, "R9 entry vector", pc_data, 32'h18);
      idle_check();

      // Held request gives one strobe per sampled cycle (R10)
      @(negedge clk);
      swi_req = 1'b1;
      @(negedge clk);
      check(entry_o && code_o == 3'd2, "R10 held first", code_o, 2);
      @(negedge clk);
      swi_req = 1'b0;
      check(entry_o && code_o == 3'd2, "R10 held second", code_o, 2);
      idle_check();

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule